// File: doc/BRIEF.md
# Address-Decoded Interrupt Source State Bank

This block holds a two-bit state for each of a set of interrupt sources. The high bit, P, marks an event that has been forwarded and not yet retired. The low bit, Q, records that a further event arrived while P was set. Software drives the state only through a load/store request port. For each request, the source index, the page offset and the access direction together select the operation. A load can return the old state and install a new one in the same access. A store carries no data, and only its address and direction count.

Each source has a management page. A source driven by a pulse also has a trigger page, and a store to it fires the source. Sources configured as level type have no trigger page and retire their event with a load-form end-of-interrupt. Every source can also be fired by a rising edge on its line input. When a state change calls for delivery, the block posts a notification naming the source toward a downstream event router. Notifications waiting in the same cycle leave one per cycle, lowest source index first.

A load at the reset offset returns the old state with Q in it. When Q is 1, software must fire the source again so that the coalesced event is not lost. The bank supports that pattern directly: the reset leaves the source in 00, so the next trigger forwards a fresh notification.

Top module: `srcstate_bank`

## Requirements
- R1: After reset every source is in state 00, and no response or notification is presented.
- R2: A load to management offset 0xC00 returns the old state in bits [1:0] (P in bit 1, Q in bit 0, other bits zero) and leaves the source in 00.
- R3: A load to management offset 0xD00 returns the old state in the same format and leaves the source in 01, the masked state.
- R4: A trigger moves 00 to 10 and forwards a notification, moves 10 to 11, and leaves 11 and 01 unchanged without notification. A trigger is either a store at any offset of a pulse source's trigger page (req_trig=1) or a rising edge on the source's line input.
- R5: A store to management offset 0x400 is a store-form end-of-interrupt. It moves 10 to 00, moves 11 to 10 and forwards a notification, and leaves 00 and 01 unchanged.
- R6: On a level source, a load to management offset 0x000 returns the old state and applies the end-of-interrupt transition of R5. If the line input is still high in that cycle, a trigger is then applied to the result, so 10 with the line high ends in 10 with a new notification.
- R7: Level sources (LEVEL_MASK bit set) have no trigger page: a store there has no effect and a load there returns all ones. On a pulse source, a load at offset 0x000 returns all ones and has no effect.
- R8: A load at any other management offset returns all ones. A store at any offset other than 0x400 has no effect on the state.
- R9: Every load is answered with rsp_valid in the cycle after it is accepted. Stores and idle cycles produce no response.
- R10: When several notifications become due in the same cycle, they are presented on consecutive cycles, one at a time, lowest source index first, and none is lost.
- R11: When a request and a line edge reach the same source in one cycle, the request's transition is applied first and the trigger after it. For example, an end-of-interrupt from 11 together with an edge ends in 11 with one notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_trig | input | 1 | 1 = trigger page, 0 = management page |
| req_src | input | $clog2(NUM_SRC) | Source index |
| req_off | input | 12 | Offset within the page |
| line_in | input | NUM_SRC | Per-source event lines, rising edge fires |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | DATA_W | Load response data |
| notify_valid | output | 1 | Notification present |
| notify_src | output | $clog2(NUM_SRC) | Source being notified |

## Verification
The two functions that can coincide are a software request and a line edge. They meet in two ways: on the same source in one cycle, or on different sources, each asking for a notification in the same cycle. The bench drives a store-form end-of-interrupt together with a line pulse on one source, and a trigger-page store together with a line pulse on another pair. It then judges the final state with a reset-offset probe, and judges the order and count of notifications seen at the output. A full sweep of every source, starting state and operation checks the single-operation behaviour against an arithmetic model.

// File: rtl/srcstate_pkg.sv
// Shared types and helpers for the interrupt source state bank.
// Assumes a 12-bit page offset and a two-bit P/Q state per source.
package srcstate_pkg;

    localparam int PAGE_OFF_W = 12;

    localparam logic [PAGE_OFF_W-1:0] OFF_EOI_LOAD  = 12'h000;
    localparam logic [PAGE_OFF_W-1:0] OFF_EOI_STORE = 12'h400;
    localparam logic [PAGE_OFF_W-1:0] OFF_SET_OPEN  = 12'hC00;
    localparam logic [PAGE_OFF_W-1:0] OFF_SET_MASK  = 12'hD00;

    typedef logic [1:0] pq_t;

    localparam pq_t PQ_IDLE   = 2'b00;
    localparam pq_t PQ_MASKED = 2'b01;
    localparam pq_t PQ_PEND   = 2'b10;
    localparam pq_t PQ_PEND_Q = 2'b11;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_OPEN,
        OP_MASK,
        OP_EOI_ST,
        OP_EOI_LD,
        OP_VOID_LD
    } pq_op_e;

    typedef struct packed {
        pq_t  st;
        logic fwd;
    } pq_step_t;

    // End-of-interrupt transition
    function automatic pq_step_t pq_eoi(input pq_t s);
        pq_step_t r;
        r.st  = s;
        r.fwd = 1'b0;
        if (s == PQ_PEND) begin
            r.st = PQ_IDLE;
        end else if (s == PQ_PEND_Q) begin
            r.st  = PQ_PEND;
            r.fwd = 1'b1;
        end
        return r;
    endfunction

    // Trigger transition
    function automatic pq_step_t pq_trigger(input pq_t s);
        pq_step_t r;
        r.st  = s;
        r.fwd = 1'b0;
        if (s == PQ_IDLE) begin
            r.st  = PQ_PEND;
            r.fwd = 1'b1;
        end else if (s == PQ_PEND) begin
            r.st = PQ_PEND_Q;
        end
        return r;
    endfunction

endpackage

// File: rtl/srcstate_decode.sv
// Request decoder: turns direction, page select and offset into one operation.
// Assumes the caller supplies whether the addressed source is level type.
module srcstate_decode
    import srcstate_pkg::*;
(
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_trig,
    input  logic [PAGE_OFF_W-1:0] req_off,
    input  logic                  src_level,
    output pq_op_e                op,
    output logic                  is_load
);

    // Select the operation from address and direction only
    always_comb begin
        op = OP_NONE;
        if (req_valid) begin
            if (req_trig) begin
                if (!req_write)     op = OP_VOID_LD;
                else if (!src_level) op = OP_TRIG;
                else                op = OP_NONE;
            end else if (req_write) begin
                op = (req_off == OFF_EOI_STORE) ? OP_EOI_ST : OP_NONE;
            end else begin
                case (req_off)
                    OFF_SET_OPEN: op = OP_OPEN;
                    OFF_SET_MASK: op = OP_MASK;
                    OFF_EOI_LOAD: op = src_level ? OP_EOI_LD : OP_VOID_LD;
                    default:      op = OP_VOID_LD;
                endcase
            end
        end
    end

    // Every accepted load gets a response
    assign is_load = req_valid & ~req_write;

endmodule

// File: rtl/srcstate_cell.sv
// One source: P/Q state register, line edge detector and transition logic.
// Assumes op is OP_NONE unless this source is addressed (hit).
module srcstate_cell
    import srcstate_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    input  pq_op_e op,
    input  logic   line_in,
    output pq_t    pq,
    output logic   fwd
);

    pq_t      pq_q;
    logic     line_d;
    logic     line_rise;
    logic     req_fire;
    pq_step_t after_req;
    pq_step_t after_trig;
    pq_t      pq_next;

    assign line_rise = line_in & ~line_d;

    // Apply the request first, then any trigger on the result
    always_comb begin
        after_req.st  = pq_q;
        after_req.fwd = 1'b0;
        req_fire      = 1'b0;
        if (hit) begin
            case (op)
                OP_OPEN:   after_req.st = PQ_IDLE;
                OP_MASK:   after_req.st = PQ_MASKED;
                OP_EOI_ST: after_req = pq_eoi(pq_q);
                OP_EOI_LD: begin
                    after_req = pq_eoi(pq_q);
                    req_fire  = IS_LEVEL && line_in;
                end
                OP_TRIG:   req_fire = 1'b1;
                default:   ;
            endcase
        end
        after_trig = after_req;
        if (req_fire || line_rise) begin
            after_trig     = pq_trigger(after_req.st);
            after_trig.fwd = after_trig.fwd | after_req.fwd;
        end
        pq_next = after_trig.st;
        fwd     = after_trig.fwd;
    end

    // State and line history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_q   <= PQ_IDLE;
            line_d <= 1'b0;
        end else begin
            pq_q   <= pq_next;
            line_d <= line_in;
        end
    end

    assign pq = pq_q;

endmodule

// File: rtl/srcstate_notify.sv
// Notification collector: one pending flag per source, drained one per cycle,
// lowest index first. Assumes a new request for a flag being granted is kept.
module srcstate_notify #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    output logic               notify_valid,
    output logic [IDX_W-1:0]   notify_src
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   pick;

    // Find the lowest pending source
    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = IDX_W'(i);
        end
        grant = (|pend_q) ? (NUM_SRC'(1) << pick) : '0;
    end

    // Retire the granted flag, record new ones
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant) | set_vec;
    end

    assign notify_valid = |pend_q;
    assign notify_src   = pick;

endmodule

// File: rtl/srcstate_bank.sv
// Bank of P/Q interrupt source states driven by address-decoded loads/stores.
// Assumes one request per cycle; the load response is registered, one cycle.
module srcstate_bank
    import srcstate_pkg::*;
#(
    parameter int                NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
    parameter int                DATA_W     = 8,
    localparam int               IDX_W      = $clog2(NUM_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_trig,
    input  logic [IDX_W-1:0]      req_src,
    input  logic [PAGE_OFF_W-1:0] req_off,
    input  logic [NUM_SRC-1:0]    line_in,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  notify_valid,
    output logic [IDX_W-1:0]      notify_src
);

    pq_op_e              op;
    logic                is_load;
    pq_t                 pq_arr [NUM_SRC];
    logic [NUM_SRC-1:0]  fwd_vec;
    logic [2*NUM_SRC-1:0] state_vec;
    logic                rsp_valid_q;
    logic [DATA_W-1:0]   rsp_data_q;

    srcstate_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_trig  (req_trig),
        .req_off   (req_off),
        .src_level (LEVEL_MASK[req_src]),
        .op        (op),
        .is_load   (is_load)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        srcstate_cell #(
            .IS_LEVEL (LEVEL_MASK[g])
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (req_src == IDX_W'(g)),
            .op      (op),
            .line_in (line_in[g]),
            .pq      (pq_arr[g]),
            .fwd     (fwd_vec[g])
        );
        assign state_vec[2*g +: 2] = pq_arr[g];
    end

    srcstate_notify #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_notify (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_vec      (fwd_vec),
        .notify_valid (notify_valid),
        .notify_src   (notify_src)
    );

    // Register the load response: old state or all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= is_load;
            if (is_load) begin
                rsp_data_q <= (op == OP_VOID_LD) ? '1 : DATA_W'(pq_arr[req_src]);
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/srcstate_bank_chk.sv
// Property checker for srcstate_bank, attached by bind.
module srcstate_bank_chk
    import srcstate_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  req_trig,
    input logic [IDX_W-1:0]      req_src,
    input logic [PAGE_OFF_W-1:0] req_off,
    input logic                  rsp_valid,
    input logic [DATA_W-1:0]     rsp_data,
    input logic [2*NUM_SRC-1:0]  state_vec
);

    logic [IDX_W-1:0] src_d;
    logic [1:0]       pq_d;
    logic             mgmt_load;

    // Remember last addressed source
    always_ff @(posedge clk) begin
        if (!rst_n) src_d <= '0;
        else        src_d <= req_src;
    end

    assign pq_d      = state_vec[int'(src_d)*2 +: 2];
    assign mgmt_load = req_valid && !req_write && !req_trig;

    a_r9_rsp_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    a_r9_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    a_r3_mask_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_load && req_off == OFF_SET_MASK) |=> (pq_d == 2'b01));

    a_r2_open_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_load && req_off == OFF_SET_OPEN) |=> (pq_d[0] == 1'b0));

    a_r2_rsp_format: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data != '1) |-> (rsp_data[DATA_W-1:2] == '0));

endmodule

bind srcstate_bank srcstate_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_trig  (req_trig),
    .req_src   (req_src),
    .req_off   (req_off),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .state_vec (state_vec)
);

// File: tb/tb_srcstate_bank.sv
module tb_srcstate_bank;

    localparam int NSRC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_trig = 1'b0;
    logic [2:0] req_src = '0;
    logic [11:0] req_off = '0;
    logic [7:0] line_in = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       notify_valid;
    logic [2:0] notify_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int got_ntf [NSRC];
    int exp_ntf [NSRC];
    int ntf_log [64];
    int n_log = 0;
    logic [1:0] m_pq [NSRC];

    srcstate_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_trig(req_trig), .req_src(req_src), .req_off(req_off), .line_in(line_in),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .notify_valid(notify_valid), .notify_src(notify_src)
    );

    always #5 clk = ~clk;

    // Notification monitor
    always @(negedge clk) begin
        if (rst_n && notify_valid) begin
            got_ntf[notify_src] = got_ntf[notify_src] + 1;
            if (n_log < 64) ntf_log[n_log] = int'(notify_src);
            n_log = n_log + 1;
        end
    end

    function automatic bit is_lvl(input int s);
        return s >= 4;
    endfunction

    task automatic check(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Model transitions from the requirements
    task automatic m_trigger(input int s);
        case (m_pq[s])
            2'b00: begin m_pq[s] = 2'b10; exp_ntf[s]++; end
            2'b10: m_pq[s] = 2'b11;
            default: ;
        endcase
    endtask

    task automatic m_eoi(input int s);
        case (m_pq[s])
            2'b10: m_pq[s] = 2'b00;
            2'b11: begin m_pq[s] = 2'b10; exp_ntf[s]++; end
            default: ;
        endcase
    endtask

    task automatic access(input int s, input logic wr, input logic trg, input logic [11:0] off,
                          output logic [7:0] rd, output logic rv);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_trig = trg; req_src = 3'(s); req_off = off;
        @(negedge clk);
        rd = rsp_data; rv = rsp_valid;
        req_valid = 0; req_write = 0; req_trig = 0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); line_in[s] = 1'b1;
        @(negedge clk); line_in[s] = 1'b0;
    endtask

    task automatic fire(input int s);
        logic [7:0] d; logic v;
        if (is_lvl(s)) pulse(s);
        else access(s, 1'b1, 1'b1, 12'h000, d, v);
        m_trigger(s);
    endtask

    task automatic settle_and_count(input string req);
        repeat (10) @(negedge clk);
        for (int s = 0; s < NSRC; s++) check(got_ntf[s], exp_ntf[s], req, "notify count");
    endtask

    task automatic probe(input int s, input string req);
        logic [7:0] d; logic v;
        access(s, 1'b0, 1'b0, 12'hC00, d, v);
        check(int'(d), int'(m_pq[s]), req, "state probe");
        m_pq[s] = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic v;
        int exp_rsp;
        string rq;
        for (int s = 0; s < NSRC; s++) begin m_pq[s] = 0; got_ntf[s] = 0; exp_ntf[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(int'(rsp_valid), 0, "R1", "rsp_valid after reset");
        check(int'(notify_valid), 0, "R1", "notify_valid after reset");
        for (int s = 0; s < NSRC; s++) probe(s, "R1");

        // Sweep: every source, every starting state, every operation
        for (int s = 0; s < NSRC; s++) begin
            for (int init = 0; init < 4; init++) begin
                for (int op = 0; op < 9; op++) begin
                    if (init == 1) access(s, 1'b0, 1'b0, 12'hD00, d, v);
                    if (init == 1) m_pq[s] = 2'b01;
                    if (init >= 2) fire(s);
                    if (init == 3) fire(s);
                    exp_rsp = -1;
                    case (op)
                        0: begin
                            rq = is_lvl(s) ? "R7" : "R4";
                            access(s, 1'b1, 1'b1, 12'h000, d, v);
                            if (!is_lvl(s)) m_trigger(s);
                        end
                        1: begin rq = "R2"; exp_rsp = m_pq[s];
                            access(s, 1'b0, 1'b0, 12'hC00, d, v); m_pq[s] = 2'b00; end
                        2: begin rq = "R3"; exp_rsp = m_pq[s];
                            access(s, 1'b0, 1'b0, 12'hD00, d, v); m_pq[s] = 2'b01; end
                        3: begin rq = "R5"; access(s, 1'b1, 1'b0, 12'h400, d, v); m_eoi(s); end
                        4: begin
                            rq = is_lvl(s) ? "R6" : "R7";
                            exp_rsp = is_lvl(s) ? int'(m_pq[s]) : 8'hFF;
                            access(s, 1'b0, 1'b0, 12'h000, d, v);
                            if (is_lvl(s)) m_eoi(s);
                        end
                        5: begin rq = "R8"; exp_rsp = 8'hFF; access(s, 1'b0, 1'b0, 12'h800, d, v); end
                        6: begin rq = "R8"; access(s, 1'b1, 1'b0, 12'hC00, d, v); end
                        7: begin rq = "R7"; exp_rsp = 8'hFF; access(s, 1'b0, 1'b1, 12'h010, d, v); end
                        default: begin rq = "R4"; pulse(s); m_trigger(s); v = 1'b0; end
                    endcase
                    if (exp_rsp >= 0) begin
                        check(int'(v), 1, "R9", "load response valid");
                        check(int'(d), exp_rsp, rq, "load data");
                    end else if (op != 8) begin
                        check(int'(v), 0, "R9", "store gives no response");
                    end
                    probe(s, rq);
                    settle_and_count(rq);
                end
            end
        end

        // R6: level source, line held high across load-form EOI
        @(negedge clk); line_in[5] = 1'b1; m_trigger(5);
        access(5, 1'b0, 1'b0, 12'h000, d, v);
        check(int'(d), 2, "R6", "eoi load with line high, old state");
        m_eoi(5); m_trigger(5);
        @(negedge clk); line_in[5] = 1'b0;
        probe(5, "R6");
        settle_and_count("R6");

        // R11: store EOI from 11 with a line edge on the same source, same cycle
        fire(1); fire(1);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_trig = 0; req_src = 3'd1; req_off = 12'h400;
        line_in[1] = 1'b1;
        @(negedge clk);
        req_valid = 0; req_write = 0; line_in[1] = 1'b0;
        m_eoi(1); m_trigger(1);
        probe(1, "R11");
        settle_and_count("R11");

        // R10: two sources due in the same cycle, drained lowest first
        n_log = 0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_trig = 1; req_src = 3'd6; req_off = 12'h000;
        line_in[6] = 1'b0; line_in[2] = 1'b1;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_trig = 0; line_in[2] = 1'b0;
        m_trigger(2);
        repeat (4) @(negedge clk);
        check(n_log, 1, "R10", "level trig-page store ignored, one notification");
        n_log = 0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_trig = 1; req_src = 3'd3; req_off = 12'h000;
        line_in[6] = 1'b1;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_trig = 0; line_in[6] = 1'b0;
        m_trigger(3); m_trigger(6);
        repeat (4) @(negedge clk);
        check(n_log, 2, "R10", "notifications delivered");
        check(ntf_log[0], 3, "R10", "first notified source");
        check(ntf_log[1], 6, "R10", "second notified source");
        probe(2, "R10"); probe(3, "R10"); probe(6, "R10");
        settle_and_count("R10");

        finish_run();
    end

endmodule